// File: doc/BRIEF.md
# Ping-pong frame buffer controller

This block sits between a host expansion bus, a video digitizer and two byte-wide field memories. While one memory takes digitized samples from the capture side, the host reads the other one through a 64 KB memory window, so readout and capture run in parallel. The host swaps the roles of the two memories by writing a control port in the I/O space. The controller applies a requested swap only while the video is in vertical blanking, so no field is ever split across both memories.

Each memory holds 128 KB, which is one field of 512 samples by 256 lines. The host window covers only half of a memory, so the top bank-address bit comes from a page bit that the host writes through the same control port. The capture path runs on the sample clock. It writes one sample per active pixel into the capture memory at an address counter that restarts every vertical blanking interval. The host read path is combinational from the bus strobes. The port write is seen by the sample-clock domain through a synchronizer.

Top module: `pp_fb_ctrl`

## Requirements
- R1: During reset both write strobes and both output enables are high (inactive), `host_drv_o` is 0, and after reset the role flag and the page bit are 0.
- R2: A host read is active when `host_memr_ni` is low and host address bits 19..16 equal 4'b1101 (window 0xD0000–0xDFFFF), whatever `host_aen_i` is. It raises `host_drv_o` and pulls low the output enable of the host-role bank only. Outside that window, or with `host_memr_ni` high, both enables stay high.
- R3: A control write is accepted only when address bits 9..4 equal 6'b100010 (ports 0x220–0x22F) and `host_aen_i` is low. It completes on the rising edge of (port select OR `host_iow_ni`). Data bit 0 is then the requested role flag and data bit 1 is the page bit. A write with `host_aen_i` high, or to any other port, changes nothing.
- R4: A requested role flag takes effect only on a clock edge where `cap_vblank_i` is high. Outside vertical blanking the roles stay as they are.
- R5: With role flag 0, the host reads bank 0 and capture writes bank 1. With flag 1, the roles are swapped. The host-role bank is never written.
- R6: A sample is written only when `cap_hblank_i` and `cap_vblank_i` are both low at a clock edge. In the following cycle the capture bank's write strobe is low for one cycle and `ram_wdata_o` carries that sample.
- R7: The capture address is cleared on every edge with `cap_vblank_i` high. It advances by one per written sample and holds its value through horizontal blanking.
- R8: The host-role bank address is {page bit, host address bits 15..0}. The capture-role bank address is the capture address of the sample being written.
- R9: `host_rdata_o` carries the read data of the host-role bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 20 | Host address bus |
| host_aen_i | input | 1 | High during a DMA cycle, blocks port decode |
| host_iow_ni | input | 1 | Host I/O write strobe, active low |
| host_memr_ni | input | 1 | Host memory read strobe, active low |
| host_ctrl_i | input | 2 | Host data bits 1..0 for the control port |
| cap_hblank_i | input | 1 | Horizontal blanking flag |
| cap_vblank_i | input | 1 | Vertical blanking flag |
| cap_sample_i | input | 8 | Digitized sample |
| ram_rdata_i | input | 2x8 | Read data of each bank |
| ram_addr_o | output | 2x17 | Address of each bank |
| ram_we_no | output | 2 | Write strobe of each bank, active low |
| ram_oe_no | output | 2 | Output enable of each bank, active low |
| ram_wdata_o | output | 8 | Capture data to both banks |
| host_rdata_o | output | 8 | Read data to the host |
| host_drv_o | output | 1 | Host data driver enable |

## Verification
Two kinds of activity can fall in the same cycle. A host read or control write can land while a capture write is in flight, and that is the whole point of the block. The bench keeps a stream of active samples running while it issues a control write that requests a swap, and then a window read. In that one cycle it checks that the capture strobe still targets the old capture bank and that the read enable and read data come from the other bank. It then checks that the swap happens only once vertical blanking arrives, through a read of data captured in the previous field.

// File: rtl/pp_fb_pkg.sv
package pp_fb_pkg;
  localparam int unsigned NUM_BANKS = 2;

  // bank used by capture for a given role flag; host gets the other one
  function automatic logic cap_bank(input logic role);
    return ~role;
  endfunction
endpackage

// File: rtl/pp_host_if.sv
module pp_host_if #(
  parameter logic [5:0] PORT_MATCH = 6'b100010,
  parameter int unsigned WSEL_W = 4,
  parameter logic [WSEL_W-1:0] WIN_MATCH = 4'b1101,
  parameter int unsigned CTRL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [5:0]        port_field_i,
  input  logic [WSEL_W-1:0] win_field_i,
  input  logic              aen_i,
  input  logic              iow_ni,
  input  logic              memr_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              req_role_o,
  output logic [CTRL_W-2:0] page_o,
  output logic              host_rd_o
);
  logic              port_sel_n;
  logic              win_sel_n;
  logic              pw_clk;
  logic [2:0]        pw_q;
  logic [CTRL_W-1:0] d_hold;

  assign port_sel_n = ~((port_field_i == PORT_MATCH) & ~aen_i);
  assign win_sel_n  = ~(win_field_i == WIN_MATCH);
  assign pw_clk     = port_sel_n | iow_ni;
  assign host_rd_o  = ~win_sel_n & ~memr_ni;

  // port-write strobe resynchronised; commit on its rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_q       <= '1;
      d_hold     <= '0;
      req_role_o <= 1'b0;
      page_o     <= '0;
    end else begin
      pw_q <= {pw_q[1:0], pw_clk};
      if (!pw_q[1]) d_hold <= ctrl_i;
      if (pw_q[1] && !pw_q[2]) begin
        req_role_o <= d_hold[0];
        page_o     <= d_hold[CTRL_W-1:1];
      end
    end
  end
endmodule

// File: rtl/pp_capture.sv
module pp_capture #(
  parameter int unsigned BANK_AW = 17,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hblank_i,
  input  logic               vblank_i,
  input  logic [DATA_W-1:0]  sample_i,
  input  logic               req_role_i,
  output logic               role_o,
  output logic               wr_en_o,
  output logic [BANK_AW-1:0] wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o
);
  logic               cap_en;
  logic [BANK_AW-1:0] cnt_q;

  assign cap_en = ~hblank_i & ~vblank_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      role_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      cnt_q     <= '0;
    end else begin
      wr_en_o <= cap_en;
      if (vblank_i) begin
        role_o <= req_role_i;   // swap only between fields
        cnt_q  <= '0;
      end else if (cap_en) begin
        cnt_q <= cnt_q + BANK_AW'(1);
      end
      if (cap_en) begin
        wr_addr_o <= cnt_q;
        wr_data_o <= sample_i;
      end
    end
  end
endmodule

// File: rtl/pp_bank_mux.sv
module pp_bank_mux #(
  parameter int unsigned BANK_AW = 17,
  parameter int unsigned WIN_AW  = 16,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned PAGE_W = BANK_AW - WIN_AW
) (
  input  logic                                 role_i,
  input  logic                                 host_rd_i,
  input  logic [WIN_AW-1:0]                    win_addr_i,
  input  logic [PAGE_W-1:0]                    page_i,
  input  logic                                 wr_en_i,
  input  logic [BANK_AW-1:0]                   wr_addr_i,
  input  logic [pp_fb_pkg::NUM_BANKS-1:0][DATA_W-1:0]  ram_rdata_i,
  output logic [pp_fb_pkg::NUM_BANKS-1:0][BANK_AW-1:0] ram_addr_o,
  output logic [pp_fb_pkg::NUM_BANKS-1:0]              ram_we_no,
  output logic [pp_fb_pkg::NUM_BANKS-1:0]              ram_oe_no,
  output logic [DATA_W-1:0]                    host_rdata_o
);
  logic [BANK_AW-1:0] host_addr;
  logic               cbank;

  assign host_addr = {page_i, win_addr_i};
  assign cbank     = pp_fb_pkg::cap_bank(role_i);

  for (genvar b = 0; b < pp_fb_pkg::NUM_BANKS; b++) begin : g_bank
    localparam logic IDX = 1'(b);
    logic is_cap;
    assign is_cap        = (cbank == IDX);
    assign ram_addr_o[b] = is_cap ? wr_addr_i : host_addr;
    assign ram_we_no[b]  = ~(wr_en_i & is_cap);
    assign ram_oe_no[b]  = ~(host_rd_i & ~is_cap);
  end

  assign host_rdata_o = ram_rdata_i[role_i];
endmodule

// File: rtl/pp_fb_ctrl.sv
module pp_fb_ctrl #(
  parameter int unsigned BANK_AW = 17,
  parameter int unsigned WIN_AW  = 16,
  parameter int unsigned HOST_AW = 20,
  parameter int unsigned DATA_W  = 8,
  parameter logic [5:0]  PORT_MATCH = 6'b100010,
  parameter logic [HOST_AW-WIN_AW-1:0] WIN_MATCH = 4'b1101
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [HOST_AW-1:0]                host_addr_i,
  input  logic                              host_aen_i,
  input  logic                              host_iow_ni,
  input  logic                              host_memr_ni,
  input  logic [BANK_AW-WIN_AW:0]           host_ctrl_i,
  input  logic                              cap_hblank_i,
  input  logic                              cap_vblank_i,
  input  logic [DATA_W-1:0]                 cap_sample_i,
  input  logic [1:0][DATA_W-1:0]            ram_rdata_i,
  output logic [1:0][BANK_AW-1:0]           ram_addr_o,
  output logic [1:0]                        ram_we_no,
  output logic [1:0]                        ram_oe_no,
  output logic [DATA_W-1:0]                 ram_wdata_o,
  output logic [DATA_W-1:0]                 host_rdata_o,
  output logic                              host_drv_o
);
  localparam int unsigned PAGE_W = BANK_AW - WIN_AW;
  localparam int unsigned WSEL_W = HOST_AW - WIN_AW;

  logic               req_role;
  logic [PAGE_W-1:0]  page;
  logic               host_rd;
  logic               active_sel;
  logic               wr_en;
  logic [BANK_AW-1:0] wr_addr;

  pp_host_if #(
    .PORT_MATCH(PORT_MATCH), .WSEL_W(WSEL_W), .WIN_MATCH(WIN_MATCH), .CTRL_W(PAGE_W + 1)
  ) i_host_if (
    .clk_i, .rst_ni,
    .port_field_i(host_addr_i[9:4]),
    .win_field_i (host_addr_i[HOST_AW-1:WIN_AW]),
    .aen_i       (host_aen_i),
    .iow_ni      (host_iow_ni),
    .memr_ni     (host_memr_ni),
    .ctrl_i      (host_ctrl_i),
    .req_role_o  (req_role),
    .page_o      (page),
    .host_rd_o   (host_rd)
  );

  pp_capture #(.BANK_AW(BANK_AW), .DATA_W(DATA_W)) i_capture (
    .clk_i, .rst_ni,
    .hblank_i  (cap_hblank_i),
    .vblank_i  (cap_vblank_i),
    .sample_i  (cap_sample_i),
    .req_role_i(req_role),
    .role_o    (active_sel),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (ram_wdata_o)
  );

  pp_bank_mux #(.BANK_AW(BANK_AW), .WIN_AW(WIN_AW), .DATA_W(DATA_W)) i_bank_mux (
    .role_i      (active_sel),
    .host_rd_i   (host_rd),
    .win_addr_i  (host_addr_i[WIN_AW-1:0]),
    .page_i      (page),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .ram_rdata_i (ram_rdata_i),
    .ram_addr_o  (ram_addr_o),
    .ram_we_no   (ram_we_no),
    .ram_oe_no   (ram_oe_no),
    .host_rdata_o(host_rdata_o)
  );

  assign host_drv_o = host_rd;
endmodule

// File: rtl/pp_fb_checker.sv
module pp_fb_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cap_hblank_i,
  input logic       cap_vblank_i,
  input logic [1:0] ram_we_no,
  input logic [1:0] ram_oe_no,
  input logic       host_drv_o,
  input logic       active_sel_i
);
  // R4: roles move only on a vertical blanking edge
  a_r4_swap_in_vblank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_vblank_i |=> $stable(active_sel_i));

  // R6: blanking at an edge means no write strobe in the next cycle
  a_r6_no_blank_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_hblank_i || cap_vblank_i) |=> (ram_we_no == 2'b11));

  a_r6_single_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ram_we_no));

  // R5: host-role bank is never written, capture-role bank never read
  a_r5_host_bank_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_no[active_sel_i] && ram_oe_no[~active_sel_i]);

  // R2: a host read enables exactly one bank
  a_r2_one_reader: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_drv_o |-> $onehot(~ram_oe_no));

  a_r2_idle_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_drv_o |-> (ram_oe_no == 2'b11));
endmodule

bind pp_fb_ctrl pp_fb_checker i_pp_fb_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cap_hblank_i(cap_hblank_i),
  .cap_vblank_i(cap_vblank_i),
  .ram_we_no   (ram_we_no),
  .ram_oe_no   (ram_oe_no),
  .host_drv_o  (host_drv_o),
  .active_sel_i(active_sel)
);

// File: tb/test_pp_fb_ctrl.sv
module test_pp_fb_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {addr[19:0], aen, memr_n, exp_drv, exp_oe_n[1:0]} with role flag 0
  localparam logic [24:0] VEC [NV] = '{
    {20'hD1234, 1'b0, 1'b0, 1'b1, 2'b10},
    {20'hD1234, 1'b0, 1'b1, 1'b0, 2'b11},
    {20'hC1234, 1'b0, 1'b0, 1'b0, 2'b11},
    {20'hDFFFF, 1'b0, 1'b0, 1'b1, 2'b10},
    {20'hD0000, 1'b1, 1'b0, 1'b1, 2'b10},
    {20'h5D000, 1'b0, 1'b0, 1'b0, 2'b11},
    {20'h00220, 1'b0, 1'b0, 1'b0, 2'b11},
    {20'hE0000, 1'b0, 1'b0, 1'b0, 2'b11}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] host_addr = '0;
  logic host_aen = 1'b0, host_iow_n = 1'b1, host_memr_n = 1'b1;
  logic [1:0] host_ctrl = '0;
  logic hblank = 1'b1, vblank = 1'b1;
  logic [7:0] sample = '0;
  logic [1:0][7:0]  ram_rdata;
  logic [1:0][16:0] ram_addr;
  logic [1:0] ram_we_n, ram_oe_n;
  logic [7:0] ram_wdata, host_rdata;
  logic host_drv;

  bit [7:0] mem0 [1024];
  bit [7:0] mem1 [1024];
  int wcnt0 = 0, wcnt1 = 0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_fb_ctrl i_pp_fb_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .host_addr_i(host_addr), .host_aen_i(host_aen), .host_iow_ni(host_iow_n),
    .host_memr_ni(host_memr_n), .host_ctrl_i(host_ctrl),
    .cap_hblank_i(hblank), .cap_vblank_i(vblank), .cap_sample_i(sample),
    .ram_rdata_i(ram_rdata), .ram_addr_o(ram_addr), .ram_we_no(ram_we_n),
    .ram_oe_no(ram_oe_n), .ram_wdata_o(ram_wdata), .host_rdata_o(host_rdata),
    .host_drv_o(host_drv)
  );

  // behavioural SRAM banks
  always @(posedge clk) begin
    if (!ram_we_n[0]) begin mem0[ram_addr[0][9:0]] <= ram_wdata; wcnt0 <= wcnt0 + 1; end
    if (!ram_we_n[1]) begin mem1[ram_addr[1][9:0]] <= ram_wdata; wcnt1 <= wcnt1 + 1; end
  end
  assign ram_rdata[0] = mem0[ram_addr[0][9:0]];
  assign ram_rdata[1] = mem1[ram_addr[1][9:0]];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic hb, input logic vb, input logic [7:0] s);
    @(negedge clk);
    hblank = hb; vblank = vb; sample = s;
    @(posedge clk); #1;
  endtask

  task automatic port_wr(input logic [19:0] a, input logic aen, input logic [1:0] d);
    @(negedge clk);
    host_addr = a; host_aen = aen; host_ctrl = d; host_iow_n = 1'b0;
    repeat (4) @(negedge clk);
    host_iow_n = 1'b1;
    repeat (5) @(negedge clk);
    host_addr = '0; host_aen = 1'b0;
  endtask

  task automatic host_rd_start(input logic [19:0] a);
    @(negedge clk);
    host_addr = a; host_memr_n = 1'b0;
    #2;
  endtask

  task automatic host_rd_end();
    @(negedge clk);
    host_memr_n = 1'b1; host_addr = '0;
  endtask

  task automatic vpulse();
    cyc(1'b1, 1'b1, 8'h00);
    cyc(1'b1, 1'b1, 8'h00);
    cyc(1'b1, 1'b0, 8'h00);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(ram_we_n == 2'b11 && ram_oe_n == 2'b11 && !host_drv, "R1 reset strobes",
          {27'd0, host_drv, ram_we_n, ram_oe_n}, 32'h0F);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R8: window decode table, role flag 0 -> host bank 0
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      host_addr = VEC[i][24:5]; host_aen = VEC[i][4]; host_memr_n = VEC[i][3];
      #2;
      check(host_drv == VEC[i][2] && ram_oe_n == VEC[i][1:0], "R2 window decode",
            {29'd0, host_drv, ram_oe_n}, {29'd0, VEC[i][2:0]});
      if (VEC[i][2])
        check(ram_addr[0] == {1'b0, VEC[i][20:5]}, "R8 host address",
              {15'd0, ram_addr[0]}, {16'd0, VEC[i][20:5]});
    end
    host_rd_end();

    // field 1 into bank 1 (R5, R6, R7)
    vpulse();
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 1'b0, 8'h10 + 8'(i));
      check(ram_we_n == 2'b01 && ram_addr[1] == 17'(i) && ram_wdata == 8'h10 + 8'(i),
            "R6 capture write timing", {ram_we_n, 5'd0, ram_addr[1], ram_wdata},
            {2'b01, 5'd0, 17'(i), 8'h10 + 8'(i)});
    end
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, 1'b0, 8'hEE);
      check(ram_we_n == 2'b11, "R6 hblank no write", {30'd0, ram_we_n}, 32'h3);
    end
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 8'h20 + 8'(i));
    cyc(1'b1, 1'b0, 8'h00);
    cyc(1'b1, 1'b0, 8'h00);
    check(mem1[8] == 8'h20 && mem1[11] == 8'h23, "R7 address holds over hblank",
          {16'd0, mem1[8], mem1[11]}, 32'h2023);
    check(mem1[12] == 8'h00, "R6 hblank sample ignored", {24'd0, mem1[12]}, 32'h0);
    check(wcnt0 == 0 && wcnt1 == 12, "R5 writes only to capture bank",
          32'(wcnt0 * 256 + wcnt1), 32'd12);

    // capture runs while a swap request and a host read arrive (R4, R5, R9)
    @(negedge clk); hblank = 1'b0; vblank = 1'b0; sample = 8'h33;
    port_wr(20'h00220, 1'b0, 2'b01);
    check(ram_we_n == 2'b01, "R4 no swap mid-field", {30'd0, ram_we_n}, 32'h1);
    host_rd_start(20'hD0003);
    check(ram_oe_n == 2'b10 && ram_we_n == 2'b01 && host_drv && host_rdata == 8'h00,
          "R5 read and write same cycle", {21'd0, host_drv, ram_oe_n, ram_we_n, host_rdata},
          {21'd0, 1'b1, 2'b10, 2'b01, 8'h00});
    host_rd_end();
    cyc(1'b1, 1'b0, 8'h00);

    vpulse();
    host_rd_start(20'hD0000);
    check(ram_oe_n == 2'b01 && host_rdata == 8'h10, "R9 swapped host reads bank 1",
          {22'd0, ram_oe_n, host_rdata}, {22'd0, 2'b01, 8'h10});
    host_rd_end();

    // field 2 into bank 0, counter restarted (R5, R7)
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b0, 8'h40 + 8'(i));
      check(ram_we_n == 2'b10 && ram_addr[0] == 17'(i), "R7 counter cleared in vblank",
            {ram_we_n, 13'd0, ram_addr[0]}, {2'b10, 13'd0, 17'(i)});
    end
    cyc(1'b1, 1'b0, 8'h00);
    cyc(1'b1, 1'b0, 8'h00);
    check(mem0[0] == 8'h40 && mem0[3] == 8'h43 && mem1[0] == 8'h10, "R5 field 2 in bank 0",
          {8'd0, mem0[0], mem0[3], mem1[0]}, 32'h404310);

    // blocked control writes (R3)
    port_wr(20'h00220, 1'b1, 2'b00);
    vpulse();
    host_rd_start(20'hD0000);
    check(ram_oe_n == 2'b01, "R3 AEN blocks port", {30'd0, ram_oe_n}, 32'h1);
    host_rd_end();
    port_wr(20'h00230, 1'b0, 2'b00);
    vpulse();
    host_rd_start(20'hD0000);
    check(ram_oe_n == 2'b01, "R3 other port ignored", {30'd0, ram_oe_n}, 32'h1);
    host_rd_end();

    // page bit (R8) and top of port range (R3)
    port_wr(20'h0022F, 1'b0, 2'b11);
    host_rd_start(20'hD0005);
    check(ram_addr[1] == 17'h10005, "R8 page bit on address", {15'd0, ram_addr[1]}, 32'h10005);
    host_rd_end();
    port_wr(20'h0022F, 1'b0, 2'b00);
    vpulse();
    host_rd_start(20'hD0005);
    check(ram_oe_n == 2'b10 && ram_addr[0] == 17'h00005, "R3 port 0x22F clears flag and page",
          {13'd0, ram_oe_n, ram_addr[0]}, {13'd0, 2'b10, 17'h00005});
    host_rd_end();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule